// File: doc/BRIEF.md
# Local Memory Responder

This block sits on the memory side of a simple single-master, single-clock local memory bus. It keeps its own word-addressed RAM. It answers each transfer with one Ready pulse. A transfer starts when a one-cycle address strobe arrives while the read strobe or the write strobe is high. The block then counts a fixed number of wait states, set by a parameter, and raises Ready for exactly one cycle. On a read, the stored word is on the read-data bus during that cycle. On a write, the selected byte lanes are committed at the clock edge that ends that cycle.

Bits are numbered big-endian on every bus: index 0 is the most significant bit. Byte-enable bit 0 selects data bits 0 to 7, which is the most significant byte. The master may keep a strobe high without a break across transfers of the same type. The next transfer may start in the cycle right after Ready. Address, byte enables and write data are captured with the address strobe, so the master may change the bus while the block waits.

Top module: `lmem_responder`

## Requirements
- R1: A synchronous active-high reset drops any pending transfer and zeroes every stored word. Ready stays low in every reset cycle and in every cycle after reset until a new transfer is accepted.
- R2: A transfer is accepted in a cycle where the address strobe is high and the read or write strobe is high. Ready is high exactly WAIT_STATES cycles later, or in the same cycle when WAIT_STATES is 0. It stays high for that one cycle only.
- R3: Ready is never high while no accepted transfer is waiting for completion.
- R4: In the Ready cycle of a read, the read-data bus carries the word stored at the transfer's word index. In every other cycle the read-data bus is all zeros.
- R5: A write with a legal byte-enable pattern updates only the byte lanes whose enable bit is 1, and the new data is visible to the next transfer. Enable bit k (k = 0 to 3) selects data bits 8k to 8k+7, so bit 0 selects the most significant byte.
- R6: The legal byte-enable patterns are 1111, 1100, 0011, 1000, 0100, 0010 and 0001, written from bit 0 to bit 3. A write with any other pattern still completes with one Ready pulse but leaves memory unchanged.
- R7: Address, byte enables and write data are sampled in the address-strobe cycle. Changes on those buses in later cycles of the same transfer have no effect.
- R8: An address strobe in the cycle right after Ready starts a new transfer, even if the read or write strobe never went low between the two transfers.
- R9: The word index is the DEPTH-wide field of the address that starts at byte-address bit 2. Higher address bits and the two byte-offset bits are ignored, so addresses that differ by DEPTH*4 refer to the same word.
- R10: An address-strobe pulse while both the read and the write strobe are low starts no transfer, raises no Ready and changes no memory.
- R11: An address-strobe pulse that arrives while a transfer is still pending is ignored. The pending transfer completes on its original schedule with its original address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for the whole block |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address, bit 0 most significant |
| bus_as | input | 1 | One-cycle pulse that starts a transfer |
| bus_rd_stb | input | 1 | High while a read transfer is in progress |
| bus_wr_stb | input | 1 | High while a write transfer is in progress |
| bus_be | input | 4 | Byte-lane enables, bit 0 selects the most significant byte |
| bus_wdata | input | 32 | Write data, bit 0 most significant |
| bus_rdata | output | 32 | Read data, valid in the Ready cycle of a read |
| bus_ready | output | 1 | One-cycle completion pulse |

## Verification
The bench builds two copies of the block side by side, one with WAIT_STATES = 2 and one with WAIT_STATES = 0, both with a 64-word memory. The two-wait-state copy is the only one where the bus can change while a transfer is pending. It therefore covers capture at the address strobe, and it also covers a stray address strobe that lands on a busy transfer. The zero-wait-state copy exercises the combinational path: Ready and read data appear in the cycle of the address strobe itself, and a transfer can follow in every cycle. The small depth lets the bench reach the index wrap with ordinary addresses.

// File: rtl/lmem_pkg.sv
package lmem_pkg;

    localparam int LANE_W = 8;
    localparam int LANES  = 4;
    localparam int WORD_W = LANE_W * LANES;

    // Internal view is little-endian numbered: lane 3 = bits 31:24 = bus lane 0.
    function automatic logic lane_mask_ok(input logic [LANES-1:0] be);
        case (be)
            4'b1111, 4'b1100, 4'b0011,
            4'b1000, 4'b0100, 4'b0010, 4'b0001: lane_mask_ok = 1'b1;
            default:                             lane_mask_ok = 1'b0;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [LANES-1:0]  be
    );
        logic [WORD_W-1:0] res;
        res = old_w;
        for (int i = 0; i < LANES; i++) begin
            if (be[i]) res[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
        end
        return res;
    endfunction

endpackage

// File: rtl/lmem_xfer_ctrl.sv
module lmem_xfer_ctrl
    import lmem_pkg::*;
#(
    parameter int IDX_W       = 6,
    parameter int WAIT_STATES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [LANES-1:0]  be_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic              ready_o,
    output logic              op_wr_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [LANES-1:0]  be_o,
    output logic [WORD_W-1:0] wdata_o
);

    localparam int CNT_W = $clog2(WAIT_STATES + 2);

    generate
        if (WAIT_STATES == 0) begin : g_zero_wait
            // Completion in the strobe cycle: the bus feeds the datapath directly.
            always_comb begin
                ready_o = !rst && as_i && (rd_i || wr_i);
                op_wr_o = wr_i;
                idx_o   = idx_i;
                be_o    = be_i;
                wdata_o = wdata_i;
            end
        end else begin : g_wait
            typedef struct packed {
                logic              pending;
                logic              is_wr;
                logic [CNT_W-1:0]  cnt;
                logic [IDX_W-1:0]  idx;
                logic [LANES-1:0]  be;
                logic [WORD_W-1:0] wdata;
            } xfer_t;

            xfer_t st_d, st_q;
            logic  done_now;

            always_comb begin
                done_now = st_q.pending && (st_q.cnt == CNT_W'(WAIT_STATES));
                st_d     = st_q;
                if (st_q.pending) begin
                    if (done_now) st_d.pending = 1'b0;
                    else          st_d.cnt     = st_q.cnt + 1'b1;
                end else if (as_i && (rd_i || wr_i)) begin
                    st_d.pending = 1'b1;
                    st_d.is_wr   = wr_i;
                    st_d.cnt     = CNT_W'(1);
                    st_d.idx     = idx_i;
                    st_d.be      = be_i;
                    st_d.wdata   = wdata_i;
                end
                if (rst) st_d = '0;
            end

            always_ff @(posedge clk) begin
                st_q <= st_d;
            end

            always_comb begin
                ready_o = !rst && done_now;
                op_wr_o = st_q.is_wr;
                idx_o   = st_q.idx;
                be_o    = st_q.be;
                wdata_o = st_q.wdata;
            end
        end
    endgenerate

endmodule

// File: rtl/lmem_lane_gate.sv
module lmem_lane_gate
    import lmem_pkg::*;
(
    input  logic             ready_i,
    input  logic             op_wr_i,
    input  logic [LANES-1:0] be_i,
    output logic             wr_en_o
);

    logic mask_ok;

    always_comb begin
        mask_ok = lane_mask_ok(be_i);
        wr_en_o = ready_i && op_wr_i && mask_ok;
    end

endmodule

// File: rtl/lmem_word_store.sv
module lmem_word_store
    import lmem_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [LANES-1:0]  be_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o
);

    logic [WORD_W-1:0] mem_d [DEPTH];
    logic [WORD_W-1:0] mem_q [DEPTH];

    always_comb begin
        rdata_o = mem_q[idx_i];
        mem_d   = mem_q;
        if (wr_en_i) mem_d[idx_i] = lane_merge(mem_q[idx_i], wdata_i, be_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/lmem_responder.sv
module lmem_responder
    import lmem_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DEPTH       = 64,
    parameter int WAIT_STATES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [0:ADDR_W-1] bus_addr,
    input  logic              bus_as,
    input  logic              bus_rd_stb,
    input  logic              bus_wr_stb,
    input  logic [0:LANES-1]  bus_be,
    input  logic [0:WORD_W-1] bus_wdata,
    output logic [0:WORD_W-1] bus_rdata,
    output logic              bus_ready
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int OFS_W = $clog2(LANES);

    // Vector assignment keeps the leftmost (most significant) bit leftmost.
    logic [ADDR_W-1:0] addr_le;
    logic [LANES-1:0]  be_le;
    logic [WORD_W-1:0] wdata_le;
    logic [WORD_W-1:0] rdata_le;
    logic [WORD_W-1:0] word_rd;
    logic              unused_addr_bits;

    logic              ready;
    logic              op_wr;
    logic              wr_en;
    logic [IDX_W-1:0]  x_idx;
    logic [LANES-1:0]  x_be;
    logic [WORD_W-1:0] x_wdata;

    always_comb begin
        addr_le          = bus_addr;
        be_le            = bus_be;
        wdata_le         = bus_wdata;
        unused_addr_bits = ^{addr_le[ADDR_W-1:IDX_W+OFS_W], addr_le[OFS_W-1:0]};
    end

    lmem_xfer_ctrl #(
        .IDX_W       (IDX_W),
        .WAIT_STATES (WAIT_STATES)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .as_i    (bus_as),
        .rd_i    (bus_rd_stb),
        .wr_i    (bus_wr_stb),
        .idx_i   (addr_le[IDX_W+OFS_W-1:OFS_W]),
        .be_i    (be_le),
        .wdata_i (wdata_le),
        .ready_o (ready),
        .op_wr_o (op_wr),
        .idx_o   (x_idx),
        .be_o    (x_be),
        .wdata_o (x_wdata)
    );

    lmem_lane_gate u_gate (
        .ready_i (ready),
        .op_wr_i (op_wr),
        .be_i    (x_be),
        .wr_en_o (wr_en)
    );

    lmem_word_store #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (wr_en),
        .idx_i   (x_idx),
        .be_i    (x_be),
        .wdata_i (x_wdata),
        .rdata_o (word_rd)
    );

    always_comb begin
        rdata_le  = (ready && !op_wr) ? word_rd : '0;
        bus_rdata = rdata_le;
        bus_ready = ready;
    end

endmodule

// File: rtl/lmem_responder_chk.sv
module lmem_responder_chk #(
    parameter int WAIT_STATES = 2
) (
    input logic clk,
    input logic rst,
    input logic bus_as,
    input logic bus_rd_stb,
    input logic bus_wr_stb,
    input logic bus_ready
);

    localparam int CW = $clog2(WAIT_STATES + 2);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic          due;
    logic          start;

    always_comb begin
        start = bus_as && (bus_rd_stb || bus_wr_stb);
        due   = (WAIT_STATES == 0) ? start : (busy_q && cnt_q == CW'(WAIT_STATES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (due) busy_q <= 1'b0;
            else     cnt_q  <= cnt_q + 1'b1;
        end else if (start && WAIT_STATES != 0) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(1);
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |-> !bus_ready);

    assert_ready_latency_R2: assert property (@(posedge clk) disable iff (rst)
        bus_ready == due);

    assert_ready_single_R2: assert property (@(posedge clk) disable iff (rst)
        (WAIT_STATES > 0 && bus_ready) |=> !bus_ready);

    assert_ready_needs_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        bus_ready |-> (bus_rd_stb || bus_wr_stb));

    assert_no_idle_ready_R3: assert property (@(posedge clk) disable iff (rst)
        (WAIT_STATES > 0 && !busy_q) |-> !bus_ready);

endmodule

bind lmem_responder lmem_responder_chk #(.WAIT_STATES(WAIT_STATES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_as     (bus_as),
    .bus_rd_stb (bus_rd_stb),
    .bus_wr_stb (bus_wr_stb),
    .bus_ready  (bus_ready)
);

// File: tb/lmem_responder_bench.sv
module lmem_harness #(
    parameter int WS    = 2,
    parameter int DEPTH = 64
) (
    input  logic clk,
    input  logic rst,
    output int   n_checks,
    output int   n_errs,
    output logic done
);

    logic [0:31] addr, wdata, rdata;
    logic [0:3]  be;
    logic        as_s, rd_s, wr_s, rdy;

    lmem_responder #(
        .ADDR_W      (32),
        .DEPTH       (DEPTH),
        .WAIT_STATES (WS)
    ) u_lmem_responder (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (addr),
        .bus_as     (as_s),
        .bus_rd_stb (rd_s),
        .bus_wr_stb (wr_s),
        .bus_be     (be),
        .bus_wdata  (wdata),
        .bus_rdata  (rdata),
        .bus_ready  (rdy)
    );

    // Reference model: big-endian vectors, behavioural.
    logic [0:31] mem [DEPTH];
    bit          m_pend;
    int          m_cnt;
    bit          m_wr;
    int          m_idx;
    logic [0:3]  m_be;
    logic [0:31] m_wd;
    bit          rdy_now;
    string       tag;

    function automatic int widx(input logic [0:31] a);
        return int'(32'(a >> 2)) % DEPTH;
    endfunction

    function automatic logic [0:31] mrg(input logic [0:31] o, input logic [0:31] d,
                                        input logic [0:3] b);
        logic [0:31] r;
        r = o;
        for (int k = 0; k < 4; k++) if (b[k]) r[k*8 +: 8] = d[k*8 +: 8];
        return r;
    endfunction

    function automatic bit legal(input logic [0:3] b);
        return ($countones(b) == 1) || b == 4'b1111 || b == 4'b1100 || b == 4'b0011;
    endfunction

    initial begin
        n_checks = 0;
        n_errs   = 0;
        m_pend   = 0;
        m_cnt    = 0;
        rdy_now  = 0;
        tag      = "R1";
    end

    always @(negedge clk) begin : model
        bit          e_rdy, t_wr;
        int          t_idx;
        logic [0:3]  t_be;
        logic [0:31] t_wd, e_rd;
        string       rt;
        e_rdy = 0; t_wr = 0; t_idx = 0; t_be = '0; t_wd = '0; e_rd = '0;
        if (!rst) begin
            if (WS == 0) begin
                if (as_s && (rd_s || wr_s)) begin
                    e_rdy = 1; t_wr = wr_s; t_idx = widx(addr); t_be = be; t_wd = wdata;
                end
            end else if (m_pend && m_cnt == WS) begin
                e_rdy = 1; t_wr = m_wr; t_idx = m_idx; t_be = m_be; t_wd = m_wd;
            end
        end
        if (e_rdy && !t_wr) e_rd = mem[t_idx];
        rt = rst ? "R1" : (e_rdy ? "R2" : "R3");
        n_checks++;
        if (rdy !== e_rdy) begin
            n_errs++;
            $display("FAIL %s WS=%0d ready act=%b exp=%b at %0t", rt, WS, rdy, e_rdy, $time);
        end
        n_checks++;
        if (rdata !== e_rd) begin
            n_errs++;
            $display("FAIL %s WS=%0d rdata act=%h exp=%h at %0t",
                     (e_rdy && !t_wr) ? tag : "R4", WS, rdata, e_rd, $time);
        end
        if (rst) begin
            m_pend = 0;
            for (int i = 0; i < DEPTH; i++) mem[i] = '0;
        end else begin
            if (e_rdy && t_wr && legal(t_be)) mem[t_idx] = mrg(mem[t_idx], t_wd, t_be);
            if (WS > 0) begin
                if (m_pend) begin
                    if (m_cnt == WS) m_pend = 0;
                    else             m_cnt++;
                end else if (as_s && (rd_s || wr_s)) begin
                    m_pend = 1; m_cnt = 1; m_wr = wr_s;
                    m_idx = widx(addr); m_be = be; m_wd = wdata;
                end
            end
        end
        rdy_now = e_rdy;
    end

    // Entered and left at posedge + 1.
    task automatic xfer(input bit w, input logic [0:31] a, input logic [0:3] b,
                        input logic [0:31] d, input bit poke);
        bit first;
        first = 1;
        as_s = 1; rd_s = !w; wr_s = w; addr = a; be = b; wdata = d;
        forever begin
            @(negedge clk); #1;
            if (rdy_now) break;
            @(posedge clk); #1;
            as_s  = poke && first;   // R11: stray strobe while pending
            first = 0;
            addr  = ~a;              // R7: bus changes while waiting
            be    = ~b;
            wdata = ~d;
        end
        @(posedge clk); #1;
        as_s = 0;
    endtask

    task automatic idle(input int n);
        as_s = 0; rd_s = 0; wr_s = 0;
        repeat (n) begin @(posedge clk); #1; end
    endtask

    initial begin
        done = 0;
        as_s = 0; rd_s = 0; wr_s = 0; addr = '0; be = '0; wdata = '0;
        wait (!rst);
        @(posedge clk); #1;
        tag = "R1"; idle(2);
        xfer(0, 32'h0000_0010, 4'b1111, '0, 0);              // R1: memory cleared
        idle(1);
        tag = "R5"; xfer(1, 32'h0000_0010, 4'b1111, 32'hA1B2C3D4, 0);
        idle(1);
        tag = "R4"; xfer(0, 32'h0000_0010, 4'b0000, '0, 0);
        idle(1);
        tag = "R5";
        xfer(1, 32'h0000_0010, 4'b1000, 32'hEE00_0000, 0);   // lane 0 = MSB
        xfer(1, 32'h0000_0010, 4'b0010, 32'h0000_5500, 0);
        xfer(1, 32'h0000_0020, 4'b1100, 32'h1234_FFFF, 0);
        xfer(1, 32'h0000_0020, 4'b0011, 32'hFFFF_5678, 0);
        xfer(0, 32'h0000_0010, 4'b1111, '0, 0);
        xfer(0, 32'h0000_0020, 4'b1111, '0, 0);
        idle(2);
        tag = "R6";
        xfer(1, 32'h0000_0010, 4'b1010, 32'h0BAD_0BAD, 0);
        xfer(1, 32'h0000_0010, 4'b0110, 32'h0BAD_0BAD, 0);
        xfer(0, 32'h0000_0010, 4'b1111, '0, 0);
        idle(1);
        tag = "R7";
        xfer(1, 32'h0000_0030, 4'b0100, 32'h00C7_0000, 0);
        xfer(0, 32'h0000_0030, 4'b1111, '0, 0);
        xfer(0, 32'h0000_0034, 4'b1111, '0, 0);
        idle(1);
        tag = "R8";
        for (int i = 0; i < 8; i++)
            xfer(1, 32'(i * 4 + 64), 4'b1111, 32'h5A00_0000 + 32'(i * 32'h0001_0203), 0);
        for (int i = 0; i < 8; i++) xfer(0, 32'(i * 4 + 64), 4'b1111, '0, 0);
        idle(1);
        tag = "R9";
        xfer(1, 32'(DEPTH * 4 + 16), 4'b0001, 32'h0000_0099, 0);
        xfer(0, 32'h0000_0010, 4'b1111, '0, 0);
        xfer(0, 32'hFFFF_FF13, 4'b1111, '0, 0);
        idle(1);
        tag = "R10";
        as_s = 1; addr = 32'h0000_0010; be = 4'b1111; wdata = 32'hDEAD_BEEF;
        @(posedge clk); #1;
        idle(WS + 2);
        xfer(0, 32'h0000_0010, 4'b1111, '0, 0);
        idle(1);
        tag = "R11";
        xfer(1, 32'h0000_0040, 4'b1111, 32'h7777_1111, 1);
        xfer(0, 32'h0000_0040, 4'b1111, '0, 1);
        xfer(0, 32'h0000_00BF, 4'b1111, '0, 0);
        idle(3);
        done = 1;
    end

endmodule

module lmem_responder_bench;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 20000;

    logic clk = 0;
    logic rst = 1;
    int   c_slow, e_slow, c_fast, e_fast;
    logic d_slow, d_fast;

    always #(CLK_PERIOD / 2) clk = ~clk;

    lmem_harness #(.WS(2), .DEPTH(64)) u_slow (
        .clk(clk), .rst(rst), .n_checks(c_slow), .n_errs(e_slow), .done(d_slow));

    lmem_harness #(.WS(0), .DEPTH(64)) u_fast (
        .clk(clk), .rst(rst), .n_checks(c_fast), .n_errs(e_fast), .done(d_fast));

    initial begin
        int  wd_errs;
        bit  finished;
        wd_errs  = 0;
        finished = 0;
        repeat (4) @(posedge clk);
        #1 rst = 0;
        for (int cyc = 0; cyc < MAX_CYCLES; cyc++) begin
            @(posedge clk);
            if (d_slow === 1'b1 && d_fast === 1'b1) begin
                finished = 1;
                break;
            end
        end
        if (!finished) begin
            wd_errs = 1;
            $display("FAIL R2 watchdog act=hung exp=done");
        end
        $display("CHECKS %0d ERRORS %0d", c_slow + c_fast + 1, e_slow + e_fast + wd_errs);
        $finish;
    end

endmodule